// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gate and Reset Sequencer

This block is the digital control core of a battery-backed SRAM controller. A flag from an external supply comparator says whether power is valid. While power is valid, the block decodes an active-low chip enable onto one of two active-low bank enables, chosen by a bank-select address bit. It also drives an active-high system reset.

When power fails, both bank enables are write-protected. An access that is already under way may finish first, but only for a bounded number of cycles. When power returns, reset and both bank enables stay blocked for a parameterized recovery window. Only then does normal decoding resume.

The power flag passes through a two-flop synchronizer. Every delay is counted in clock cycles and set by a parameter, so the windows can be scaled down for simulation.

Top module: `pfc_ctrl`

## Requirements
- R1: While `ce_ni` is high, both `bank_ce_no[0]` and `bank_ce_no[1]` are high, whatever the level of `bank_sel_i`.
- R2: In normal operation with `ce_ni` low, `bank_sel_i`=0 drives `bank_ce_no[0]` low and `bank_ce_no[1]` high, and `bank_sel_i`=1 does the reverse. The decode is combinational, so no setup time is needed before `ce_ni` falls.
- R3: If `pwr_ok_i` falls while no access is active, both bank enables are high and `rst_o` is 1 from the third rising clock edge onward. This delay is made of two synchronizer stages and one state update.
- R4: If `ce_ni` is low when the synchronized power failure is seen, the access continues to pass through. Once `ce_ni` rises, both bank enables stay high even if `ce_ni` falls again.
- R5: An access held across a power failure passes through for at most `WPT_CYC` cycles. After that, both bank enables are forced high even while `ce_ni` stays low.
- R6: After the synchronized power flag returns high, `rst_o` stays 1 and both bank enables stay high for `REL_CYC` cycles, regardless of `ce_ni`.
- R7: If power fails again during the recovery window, the block returns to the write-protected state at once. A later recovery waits the full `REL_CYC` cycles again.
- R8: While `rst_ni` is low, and after it is released until power becomes valid, `rst_o` is 1 and both bank enables are high.
- R9: `rst_o` stays 1 during an access that is being allowed to finish after a power failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Power-valid flag from comparator (asynchronous) |
| ce_ni | input | 1 | Active-low chip enable from the host |
| bank_sel_i | input | 1 | Bank select address bit |
| bank_ce_no | output | 2 | Active-low conditioned chip enables, one per bank |
| rst_o | output | 1 | Active-high system reset |

## Verification
The hardest situation to reach is an access that straddles a power failure. The chip enable must already be low when the synchronized flag drops, which happens two edges after the port changes. The stimulus therefore lowers `ce_ni` first, then drops `pwr_ok_i`, and then either releases the enable early and lowers it again, or holds it past the timeout. A power drop in the middle of the recovery window is forced the same way, by counting cycles from the return of power.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {
    ST_PROT  = 2'd0,
    ST_RECOV = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } pfc_state_e;
endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end
  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pfc_timer.sv
module pfc_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [CW-1:0] limit_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (!hit_o) cnt_q <= cnt_q + 1'b1;
  end
  assign hit_o = (cnt_q == limit_i);
endmodule

// File: rtl/pfc_decode.sv
module pfc_decode #(
  parameter int NBANK = 2,
  localparam int SW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             en_i,
  input  logic             ce_ni,
  input  logic [SW-1:0]    sel_i,
  output logic [NBANK-1:0] ce_no
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign ce_no[b] = ~(en_i & ~ce_ni & (sel_i == SW'(b)));
  end
endmodule

// File: rtl/pfc_ctrl.sv
module pfc_ctrl
  import pfc_pkg::*;
#(
  parameter int REL_CYC = 1000,
  parameter int WPT_CYC = 16,
  localparam int MAXC = (REL_CYC > WPT_CYC) ? REL_CYC : WPT_CYC,
  localparam int CW = $clog2(MAXC + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_ok_i,
  input  logic       ce_ni,
  input  logic       bank_sel_i,
  output logic [1:0] bank_ce_no,
  output logic       rst_o
);
  pfc_state_e state_q, state_d;
  logic pwr_s, tmr_clr, tmr_hit, gate_en;
  logic [CW-1:0] tmr_lim;

  pfc_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pwr_ok_i), .q_o(pwr_s)
  );

  assign tmr_lim = (state_q == ST_DRAIN) ? CW'(WPT_CYC - 1) : CW'(REL_CYC - 1);
  assign tmr_clr = (state_q != state_d);

  pfc_timer #(.CW(CW)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tmr_clr),
    .limit_i(tmr_lim), .hit_o(tmr_hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PROT:  if (pwr_s) state_d = ST_RECOV;
      ST_RECOV: if (!pwr_s) state_d = ST_PROT;
                else if (tmr_hit) state_d = ST_RUN;
      ST_RUN:   if (!pwr_s) state_d = ce_ni ? ST_PROT : ST_DRAIN;
      ST_DRAIN: if (ce_ni || tmr_hit) state_d = ST_PROT;
      default:  state_d = ST_PROT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PROT;
    else         state_q <= state_d;
  end

  assign gate_en = (state_q == ST_RUN) || (state_q == ST_DRAIN);
  assign rst_o   = (state_q != ST_RUN);

  pfc_decode #(.NBANK(2)) u_dec (
    .en_i(gate_en), .ce_ni(ce_ni), .sel_i(bank_sel_i), .ce_no(bank_ce_no)
  );
endmodule

// File: rtl/pfc_ctrl_chk.sv
module pfc_ctrl_chk
  import pfc_pkg::*;
#(
  parameter int REL_CYC = 1000,
  parameter int WPT_CYC = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_ok_i,
  input logic       ce_ni,
  input logic [1:0] bank_ce_no,
  input logic       rst_o,
  input pfc_state_e state_q
);
  int unsigned hold_cnt, leak_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_cnt <= 0;
      leak_cnt <= 0;
    end else begin
      hold_cnt <= rst_o ? hold_cnt + 1 : 0;
      leak_cnt <= (rst_o && !(&bank_ce_no)) ? leak_cnt + 1 : 0;
    end
  end

  AST_CE_HIGH_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> (&bank_ce_no)); // R1
  AST_ONE_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~bank_ce_no)); // R2
  AST_FAIL_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_ok_i && $past(!pwr_ok_i) && $past(!pwr_ok_i, 2)) |=> rst_o); // R3
  AST_DRAIN_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN && ce_ni) |=> (state_q == ST_PROT)); // R4
  AST_DRAIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leak_cnt <= WPT_CYC); // R5
  AST_RELEASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> (hold_cnt >= REL_CYC)); // R6
endmodule

bind pfc_ctrl pfc_ctrl_chk #(.REL_CYC(REL_CYC), .WPT_CYC(WPT_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_ok_i(pwr_ok_i), .ce_ni(ce_ni),
  .bank_ce_no(bank_ce_no), .rst_o(rst_o), .state_q(state_q)
);

// File: tb/tb_pfc_ctrl.sv
module tb_pfc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int REL = 20;
  localparam int WPT = 8;

  logic clk = 0, rst_ni = 0, pwr_ok = 0, ce_n = 1, bsel = 0;
  logic [1:0] bce_n;
  logic rst_o;
  int n_chk = 0, n_err = 0;
  string cur_req = "R8";
  bit done = 0;

  pfc_ctrl #(.REL_CYC(REL), .WPT_CYC(WPT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_ok_i(pwr_ok), .ce_ni(ce_n),
    .bank_sel_i(bsel), .bank_ce_no(bce_n), .rst_o(rst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model: 0 protect, 1 recover, 2 run, 3 drain
  int m_st = 0, m_n = 0;
  bit pv_q[$] = '{0, 0};

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_n = 0; pv_q = '{0, 0};
    end else begin
      bit seen;
      seen = pv_q[1];
      pv_q.pop_back();
      pv_q.push_front(pwr_ok);
      case (m_st)
        0: if (seen) begin m_st = 1; m_n = 0; end
        1: if (!seen) m_st = 0;
           else if (m_n == REL-1) m_st = 2;
           else m_n++;
        2: if (!seen) begin m_st = ce_n ? 0 : 3; m_n = 0; end
        default: if (ce_n || m_n == WPT-1) m_st = 0; else m_n++;
      endcase
    end
  end

  function automatic logic [2:0] model_out();
    bit en;
    logic [2:0] r;
    en = (m_st == 2) || (m_st == 3);
    r[0] = !(en && !ce_n && !bsel);
    r[1] = !(en && !ce_n && bsel);
    r[2] = (m_st != 2);
    return r;
  endfunction

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: {rst,ce1,ce0} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!done) check(cur_req, {rst_o, bce_n}, model_out());
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_up();
    @(negedge clk); pwr_ok = 1;
    cyc(REL + 3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int cnt;
    // R8
    #2; check("R8", {rst_o, bce_n}, 3'b111);
    cyc(3); @(negedge clk); rst_ni = 1; ce_n = 0;
    cyc(4); #1; check("R8", {rst_o, bce_n}, 3'b111);

    // R6: recovery window, ce low the whole time
    cur_req = "R6";
    @(negedge clk); pwr_ok = 1;
    cnt = 0;
    while (rst_o) begin @(negedge clk); #1; cnt++; end
    check("R6", 3'(cnt >= REL + 2), 3'd1);

    // R1/R2 decode patterns
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); ce_n = i[0]; bsel = i[1];
      cur_req = i[0] ? "R1" : "R2";
      #1; check(cur_req, {rst_o, bce_n}, i[0] ? 3'b011 : (i[1] ? 3'b001 : 3'b010));
    end

    // R3 idle power fail
    cur_req = "R3";
    @(negedge clk); ce_n = 1; pwr_ok = 0;
    cyc(3); #1; check("R3", {rst_o, bce_n}, 3'b111);
    ce_n = 0; cyc(2);
    ce_n = 1; power_up();

    // R4 access across fail, released early then reasserted
    cur_req = "R4";
    @(negedge clk); ce_n = 0; bsel = 1;
    @(negedge clk); pwr_ok = 0;
    cyc(4); #1; check("R9", {rst_o, bce_n}, 3'b101);
    @(negedge clk); ce_n = 1;
    @(negedge clk); ce_n = 0;
    cyc(2); #1; check("R4", {rst_o, bce_n}, 3'b111);
    ce_n = 1; power_up();

    // R5 access held past the timeout
    cur_req = "R5";
    @(negedge clk); ce_n = 0; bsel = 0;
    @(negedge clk); pwr_ok = 0;
    cyc(WPT + 4); #1; check("R5", {rst_o, bce_n}, 3'b111);
    ce_n = 1; power_up();

    // R7 fail during recovery
    cur_req = "R7";
    @(negedge clk); pwr_ok = 0; cyc(5);
    @(negedge clk); pwr_ok = 1; cyc(REL / 2);
    @(negedge clk); pwr_ok = 0; cyc(4);
    @(negedge clk); pwr_ok = 1; ce_n = 0;
    cnt = 0;
    while (rst_o) begin @(negedge clk); #1; cnt++; end
    check("R7", 3'(cnt >= REL + 2), 3'd1);
    cyc(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule